// File: doc/BRIEF.md
# Prescaled PWM Timer Output

This block generates one repeating pulse-width-modulated waveform from a period counter that advances once per prescaled tick. A tick lasts `2 * 2^N` input clocks, where `N` is a programmable exponent. The period is either a short one of `2^SHORT_W` ticks or a long one of `2^LONG_W` ticks. During each period the output sits at its asserted level for the first `duty` ticks. Either logic level can be selected as the asserted one.

Software-side logic presents a duty value, an exponent, a period-mode bit and a polarity bit together with a one-clock write strobe. The strobe captures all four into a shadow set. The shadow set reaches the waveform only when the running period ends, so a write never distorts the cycle that is in progress. A one-clock `period_end` strobe marks the last clock of every period. A low-pass filter on the output turns the block into a simple D/A converter.

Top module: `pwm_timer_out`

## Requirements
- R1: While reset is held and right after it, the counter, the shadow set and the active set are all zero, `pwm_out` is 0 (deasserted, active-high polarity) and `period_end` is 0.
- R2: A tick lasts `2 * 2^N` clocks for the active exponent `N`. A short period therefore lasts `2^(N+1) * 2^SHORT_W` clocks, with `period_end` asserted between two consecutive boundaries for exactly one of them.
- R3: In short mode (`wr_long`=0) only duty bits `[SHORT_W-1:0]` are used. The output is asserted for the first `duty * 2^(N+1)` clocks of each period.
- R4: In long mode (`wr_long`=1) the period is `2^LONG_W` ticks and all `LONG_W` duty bits are used, with the asserted time equal to `duty` ticks.
- R5: A duty of 0 keeps the output deasserted for the whole period.
- R6: With `wr_act_low`=1 the asserted level is logic 0, so the waveform is the inverse of the active-high one for the same duty.
- R7: A write in the middle of a period leaves the output of that period unchanged. The new values apply from the next period.
- R8: A change of exponent or period mode also takes effect only at the next period boundary.
- R9: `period_end` is a single-clock pulse on the last clock of each period and never lasts two clocks in a row.
- R10: A write whose strobe falls on the same clock as `period_end` is not used by the period that starts there. It is used from the boundary after that.
- R11: The largest duty of a mode keeps the output asserted for all but one tick of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-clock strobe that captures the four write fields into the shadow set |
| wr_duty | input | LONG_W | Duty value in ticks |
| wr_exp | input | EXP_W | Prescaler exponent N |
| wr_long | input | 1 | 1 selects the long period, 0 the short one |
| wr_act_low | input | 1 | 1 makes logic 0 the asserted level |
| pwm_out | output | 1 | Waveform output |
| period_end | output | 1 | High on the last clock of each period |

## Verification
The bench builds the block with `SHORT_W`=4, `LONG_W`=6 and `EXP_W`=2. With these values a short period lasts 32 to 256 clocks and a long one at the slowest tick lasts 1024 clocks. Many full periods in both modes, every exponent, both polarities and both ends of the duty range therefore fit in a short run. The same small widths make the write that lands on the boundary clock (R10) easy to place. The masking of short-mode duty bits can be seen within a single 16-tick period.

// File: rtl/pwm_timer_out.sv
module pwm_timer_out #(
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16,
  parameter int EXP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LONG_W-1:0] wr_duty,
  input  logic [EXP_W-1:0]  wr_exp,
  input  logic              wr_long,
  input  logic              wr_act_low,
  output logic              pwm_out,
  output logic              period_end
);
  localparam int PW = (1 << EXP_W) + 1;
  localparam logic [LONG_W-1:0] SHORT_LAST = LONG_W'((1 << SHORT_W) - 1);

  logic [LONG_W-1:0] sh_duty, ac_duty, cnt, last;
  logic [EXP_W-1:0]  sh_exp, ac_exp;
  logic              sh_long, ac_long, sh_low, ac_low;
  logic [PW-1:0]     pre_cnt, pre_lim;
  logic              tick;

  assign pre_lim    = (PW'(2) << ac_exp) - PW'(1);
  assign tick       = (pre_cnt == pre_lim);
  assign last       = ac_long ? {LONG_W{1'b1}} : SHORT_LAST;
  assign period_end = tick && (cnt == last);
  assign pwm_out    = (cnt < ac_duty) ^ ac_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_duty <= '0;
      sh_exp  <= '0;
      sh_long <= 1'b0;
      sh_low  <= 1'b0;
    end else if (wr_en) begin
      sh_duty <= wr_duty;
      sh_exp  <= wr_exp;
      sh_long <= wr_long;
      sh_low  <= wr_act_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      ac_duty <= '0;
      ac_exp  <= '0;
      ac_long <= 1'b0;
      ac_low  <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
      if (period_end) begin
        cnt     <= '0;
        ac_duty <= sh_long ? sh_duty : (sh_duty & SHORT_LAST);
        ac_exp  <= sh_exp;
        ac_long <= sh_long;
        ac_low  <= sh_low;
      end else if (tick) begin
        cnt <= cnt + LONG_W'(1);
      end
    end
  end

  assert_pe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

  assert_hold_midcycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(ac_duty) && $stable(ac_exp) && $stable(ac_long) && $stable(ac_low)));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0 && pre_cnt == '0));

  assert_short_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_long |-> (cnt <= SHORT_LAST));

  assert_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_duty == '0) |-> (pwm_out == ac_low));
endmodule

// File: tb/pwm_timer_out_tb_top.sv
module pwm_timer_out_tb_top;
  localparam int SW = 4, LW = 6, EW = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_long = 1'b0, wr_act_low = 1'b0;
  logic [LW-1:0] wr_duty = '0;
  logic [EW-1:0] wr_exp = '0;
  logic pwm_out, period_end;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pwm_timer_out #(.SHORT_W(SW), .LONG_W(LW), .EXP_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_duty(wr_duty), .wr_exp(wr_exp),
    .wr_long(wr_long), .wr_act_low(wr_act_low), .pwm_out(pwm_out), .period_end(period_end));

  // time-based reference: position in period measured in clocks
  int m_phase = 0, m_duty = 0, m_exp = 0, m_long = 0, m_low = 0;
  int s_duty = 0, s_exp = 0, s_long = 0, s_low = 0;

  function automatic int clocks_per_period();
    return (2 << m_exp) << (m_long ? LW : SW);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_duty = 0; m_exp = 0; m_long = 0; m_low = 0;
      s_duty = 0; s_exp = 0; s_long = 0; s_low = 0;
    end else begin
      if (m_phase == clocks_per_period() - 1) begin
        m_phase = 0;
        m_long = s_long; m_exp = s_exp; m_low = s_low;
        m_duty = s_long ? s_duty : s_duty % (1 << SW);
      end else m_phase++;
      if (wr_en) begin
        s_duty = int'(wr_duty); s_exp = int'(wr_exp); s_long = int'(wr_long); s_low = int'(wr_act_low);
      end
    end
  end

  task automatic check(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // per-clock comparison against the reference
  int hi_cnt = 0, len_cnt = 0, last_hi = -1, last_len = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      int e_out, e_pe;
      e_out = ((m_phase < m_duty * (2 << m_exp)) ? 1 : 0) ^ m_low;
      e_pe  = (m_phase == clocks_per_period() - 1) ? 1 : 0;
      check(cur_req, "pwm_out", int'(pwm_out), e_out);
      check("R9", "period_end", int'(period_end), e_pe);
      hi_cnt += int'(pwm_out);
      len_cnt++;
      if (period_end) begin
        last_hi = hi_cnt; last_len = len_cnt; hi_cnt = 0; len_cnt = 0;
      end
    end
  end

  task automatic write(int d, int e, int lg, int lo);
    wr_duty = LW'(d); wr_exp = EW'(e); wr_long = lg[0]; wr_act_low = lo[0];
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pe();
    do @(negedge clk); while (!period_end);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "pwm_out in reset", int'(pwm_out), 0);
    check("R1", "period_end in reset", int'(period_end), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", "pwm_out after reset", int'(pwm_out), 0);

    cur_req = "R3";
    write(5, 0, 0, 0);
    wait_pe(); wait_pe();
    check("R3", "high clocks duty5 N0", last_hi, 10);
    check("R2", "period clocks N0 short", last_len, 32);

    cur_req = "R7";
    repeat (3) @(negedge clk);
    write(9, 0, 0, 0);
    wait_pe();
    check("R7", "mid-period write keeps old duty", last_hi, 10);
    wait_pe();
    check("R7", "new duty after boundary", last_hi, 18);

    cur_req = "R5";
    write(0, 0, 0, 0);
    wait_pe(); wait_pe();
    check("R5", "zero duty high clocks", last_hi, 0);

    cur_req = "R11";
    write(15, 0, 0, 0);
    wait_pe(); wait_pe();
    check("R11", "max short duty", last_hi, 30);
    write(63, 0, 0, 0);
    wait_pe(); wait_pe();
    check("R3", "upper duty bits masked in short mode", last_hi, 30);

    cur_req = "R6";
    write(5, 0, 0, 1);
    wait_pe(); wait_pe();
    check("R6", "active-low high clocks", last_hi, 22);

    cur_req = "R8";
    write(3, 1, 0, 0);
    wait_pe();
    check("R8", "old exponent kept until boundary", last_len, 32);
    wait_pe();
    check("R2", "period clocks N1 short", last_len, 64);
    check("R3", "high clocks duty3 N1", last_hi, 12);

    write(20, 2, 1, 0);
    wait_pe();
    check("R8", "old mode kept until boundary", last_len, 64);
    wait_pe();
    check("R4", "long period clocks N2", last_len, 512);
    check("R4", "long duty20 high clocks", last_hi, 160);

    cur_req = "R11";
    write(63, 2, 1, 0);
    wait_pe(); wait_pe();
    check("R11", "max long duty", last_hi, 504);

    cur_req = "R10";
    wait_pe();
    wr_duty = LW'(10); wr_exp = EW'(2); wr_long = 1'b1; wr_act_low = 1'b0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wait_pe();
    check("R10", "boundary write not used at once", last_hi, 504);
    wait_pe();
    check("R10", "boundary write used next period", last_hi, 80);

    cur_req = "R2";
    write(1, 3, 0, 0);
    wait_pe(); wait_pe();
    check("R2", "period clocks N3 short", last_len, 256);
    check("R3", "duty1 N3 high clocks", last_hi, 16);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule